// File: doc/BRIEF.md
# I2C Target Receiver with 10-bit Addressing and Clock Stretching

This block is the receive side of an I2C target. It watches SCL and SDA through synchronizing, glitch-rejecting filters and pulls either line low through an output-enable (open-drain) signal. After a START it takes a two-byte 10-bit address, then data bytes, and answers each byte on the ninth clock with ACK (SDA held low) or NACK (SDA released). Only write transfers from the controller are handled.

The host side is a set of register-style strobes and flags. An 8-bit compare-address register is reloaded by the host between the two address bytes: it first holds the upper pattern, then the low address byte, then the upper pattern again. After every acknowledged address byte the block raises an update-needed flag and holds SCL low until that reload. Received data lands in a one-deep receive buffer with a full flag. A full buffer causes NACK and an overflow flag. An optional stretch mode holds SCL after each accepted data byte until the host releases it. A per-byte interrupt flag tells the host that a byte has ended.

Top module: `tbi_target`

## Requirements
- R1: Out of reset, sclOe, sdaOe, bufFull, ovfl, updNeeded and irq are all 0.
- R2: The first address byte after START is acknowledged only when bits 7..3 are 11110, bits 2..1 equal the compare register's bits 2..1, and bit 0 (the direction bit) is 0. Any other first byte is NACKed, sets no flag, and every later byte is NACKed until the next START.
- R3: After an acknowledged address byte, updNeeded goes to 1 and sclOe holds SCL low from the ninth-clock falling edge. A later compare-register write clears updNeeded and releases SCL.
- R4: A compare-register write registered at or before the cycle that takes in the ninth-clock falling edge updates the register but leaves updNeeded and the SCL hold set. That falling edge is taken in 3+FILT_LEN clock edges after the SCL pin falls.
- R5: The second address byte is acknowledged only when all 8 bits equal the compare register. A mismatch is NACKed, sets no flag, and the rest of the transfer is ignored until START.
- R6: A data byte that arrives with bufFull=0 is acknowledged, copied to rxData and sets bufFull. A bufRd pulse clears bufFull.
- R7: A data byte that arrives with bufFull=1 is NACKed, sets ovfl, leaves rxData unchanged and does not hold SCL. ovfClr clears ovfl.
- R8: With stretchEn=1, SCL is held low after each acknowledged data byte until a relWr pulse. With stretchEn=0 it is never held after data.
- R9: irq is set at the ninth-clock falling edge of every acknowledged address byte and of every data byte. It is cleared only by irqClr.
- R10: START (SDA falls while SCL is high) restarts address reception at any point, including mid-transfer. After STOP (SDA rises while SCL is high), bytes are ignored until a START.
- R11: An SCL pulse shorter than FILT_LEN clock cycles has no effect on reception.
- R12: sdaOe changes only while the filtered SCL is low, so an ACK is stable for the whole ninth SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | SCL pin level |
| sdaIn | input | 1 | SDA pin level |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low (ACK) |
| stretchEn | input | 1 | Hold SCL after each accepted data byte |
| addrWr | input | 1 | Compare-register write strobe |
| addrWdata | input | 8 | Compare-register write value |
| bufRd | input | 1 | Receive-buffer read strobe |
| rxData | output | 8 | Receive buffer |
| bufFull | output | 1 | Receive buffer holds unread data |
| ovfl | output | 1 | Byte arrived while buffer full |
| ovfClr | input | 1 | Clears ovfl |
| updNeeded | output | 1 | Compare register must be reloaded |
| relWr | input | 1 | Release a data-byte clock stretch |
| irq | output | 1 | Byte-complete interrupt flag |
| irqClr | input | 1 | Clears irq |

## Verification
Two events can fall in the same clock cycle: the hardware setting of the update-needed flag at the ninth-clock falling edge, and a host write of the compare register that would clear it. The bench provokes the collision by placing the host write at every offset from 0 to 8 cycles after it pulls SCL low on the ninth clock of the first address byte. It then judges each outcome against the edge latency stated in R4. Writes up to and including the detection cycle must leave both the flag and the SCL hold set, and every later write must clear both.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_IGNORE
  } rxState_e;

  typedef struct packed {
    logic shiftBit;
    logic loadBuf;
    logic setOvf;
    logic setIrq;
    logic setUpd;
  } dpStrobe_t;
endpackage

// File: rtl/tbi_line_filter.sv
module tbi_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] agreeCnt;

  // two-flop synchronizer, then accept a new level only after FILT_LEN equal samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      filtOut  <= 1'b1;
      agreeCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != filtOut) begin
        if (agreeCnt == CW'(FILT_LEN - 1)) begin
          filtOut  <= syncQ[1];
          agreeCnt <= '0;
        end else begin
          agreeCnt <= agreeCnt + CW'(1);
        end
      end else begin
        agreeCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/tbi_datapath.sv
module tbi_datapath import tbi_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic              addrWr,
  input  logic [BYTE_W-1:0] addrWdata,
  input  logic              bufRd,
  input  logic              ovfClr,
  input  logic              irqClr,
  output logic [BYTE_W-1:0] shiftQ,
  output logic [BYTE_W-1:0] addrReg,
  output logic [BYTE_W-1:0] rxData,
  output logic              bufFull,
  output logic              ovfl,
  output logic              updNeeded,
  output logic              irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      addrReg   <= '0;
      rxData    <= '0;
      bufFull   <= 1'b0;
      ovfl      <= 1'b0;
      updNeeded <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (strb.shiftBit) shiftQ <= {shiftQ[BYTE_W-2:0], sdaBit};
      if (addrWr) addrReg <= addrWdata;
      if (strb.loadBuf) rxData <= shiftQ;

      // hardware set wins over a host clear landing in the same cycle
      if (strb.loadBuf)  bufFull <= 1'b1;
      else if (bufRd)    bufFull <= 1'b0;

      if (strb.setOvf)   ovfl <= 1'b1;
      else if (ovfClr)   ovfl <= 1'b0;

      if (strb.setIrq)   irq <= 1'b1;
      else if (irqClr)   irq <= 1'b0;

      if (strb.setUpd)   updNeeded <= 1'b1;
      else if (addrWr)   updNeeded <= 1'b0;
    end
  end
endmodule

// File: rtl/tbi_ctrl.sv
module tbi_ctrl import tbi_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] shiftQ,
  input  logic [BYTE_W-1:0] addrReg,
  input  logic              bufFull,
  input  logic              stretchEn,
  input  logic              addrWr,
  input  logic              relWr,
  output dpStrobe_t         strb,
  output logic              sdaOe,
  output logic              sclOe
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
  localparam logic [3:0] ACK_BIT  = 4'(BYTE_W + 1);

  rxState_e   state;
  logic [3:0] bitCnt;
  logic       sclPrev, sdaPrev, holdAddr, holdData;
  logic       sclRise, sclFall, startCond, stopCond, busy;
  logic       decideNow, ackEndNow, hiMatch, loMatch, ackNow;

  always_comb begin
    sclRise   = sclF & ~sclPrev;
    sclFall   = ~sclF & sclPrev;
    startCond = sclF & sclPrev & sdaPrev & ~sdaF;
    stopCond  = sclF & sclPrev & ~sdaPrev & sdaF;
    busy      = (state == ST_ADDR_HI) || (state == ST_ADDR_LO) || (state == ST_DATA);
    decideNow = busy && sclFall && (bitCnt == LAST_BIT);
    ackEndNow = busy && sclFall && (bitCnt == ACK_BIT);
    hiMatch   = (shiftQ[7:3] == TEN_BIT_TAG) && (shiftQ[2:1] == addrReg[2:1]) && !shiftQ[0];
    loMatch   = (shiftQ == addrReg);
    case (state)
      ST_ADDR_HI: ackNow = hiMatch;
      ST_ADDR_LO: ackNow = loMatch;
      ST_DATA:    ackNow = !bufFull;
      default:    ackNow = 1'b0;
    endcase
    strb          = '0;
    strb.shiftBit = busy && sclRise && (bitCnt < LAST_BIT);
    strb.loadBuf  = decideNow && (state == ST_DATA) && !bufFull;
    strb.setOvf   = decideNow && (state == ST_DATA) && bufFull;
    strb.setIrq   = ackEndNow && (sdaOe || (state == ST_DATA));
    strb.setUpd   = ackEndNow && sdaOe && ((state == ST_ADDR_HI) || (state == ST_ADDR_LO));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      sdaOe    <= 1'b0;
      holdAddr <= 1'b0;
      holdData <= 1'b0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (startCond || stopCond) begin
        state    <= startCond ? ST_ADDR_HI : ST_IDLE;
        bitCnt   <= '0;
        sdaOe    <= 1'b0;
        holdAddr <= 1'b0;
        holdData <= 1'b0;
      end else begin
        if (addrWr) holdAddr <= 1'b0;
        if (relWr)  holdData <= 1'b0;
        if (busy && sclRise && (bitCnt < ACK_BIT)) bitCnt <= bitCnt + 4'd1;
        if (decideNow) begin
          sdaOe <= ackNow;
          if (!ackNow && (state != ST_DATA)) state <= ST_IGNORE;
        end
        if (ackEndNow) begin
          bitCnt <= '0;
          sdaOe  <= 1'b0;
          if (sdaOe) begin
            case (state)
              ST_ADDR_HI: begin state <= ST_ADDR_LO; holdAddr <= 1'b1; end
              ST_ADDR_LO: begin state <= ST_DATA;    holdAddr <= 1'b1; end
              ST_DATA:    holdData <= stretchEn;
              default:    ;
            endcase
          end
        end
      end
    end
  end

  assign sclOe = holdAddr | holdData;
endmodule

// File: rtl/tbi_target.sv
module tbi_target import tbi_pkg::*; #(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              stretchEn,
  input  logic              addrWr,
  input  logic [BYTE_W-1:0] addrWdata,
  input  logic              bufRd,
  output logic [BYTE_W-1:0] rxData,
  output logic              bufFull,
  output logic              ovfl,
  input  logic              ovfClr,
  output logic              updNeeded,
  input  logic              relWr,
  output logic              irq,
  input  logic              irqClr
);
  logic [1:0]        rawLines, lineF;
  logic [BYTE_W-1:0] shiftQ, addrReg;
  dpStrobe_t         strb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    tbi_line_filter #(.FILT_LEN(FILT_LEN)) uFilt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .filtOut(lineF[g])
    );
  end

  tbi_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclF(lineF[0]), .sdaF(lineF[1]),
    .shiftQ(shiftQ), .addrReg(addrReg), .bufFull(bufFull),
    .stretchEn(stretchEn), .addrWr(addrWr), .relWr(relWr),
    .strb(strb), .sdaOe(sdaOe), .sclOe(sclOe)
  );

  tbi_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(lineF[1]),
    .addrWr(addrWr), .addrWdata(addrWdata), .bufRd(bufRd),
    .ovfClr(ovfClr), .irqClr(irqClr), .shiftQ(shiftQ), .addrReg(addrReg),
    .rxData(rxData), .bufFull(bufFull), .ovfl(ovfl),
    .updNeeded(updNeeded), .irq(irq)
  );
endmodule

// File: rtl/tbi_target_chk.sv
module tbi_target_chk (
  input logic clk,
  input logic rstN,
  input logic sclF,
  input logic sclOe,
  input logic sdaOe,
  input logic updNeeded,
  input logic addrWr,
  input logic bufFull,
  input logic bufRd,
  input logic ovfl,
  input logic irq,
  input logic irqClr
);
  a_r3_upd_holds_scl: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updNeeded) |-> sclOe);

  a_r4_upd_cleared_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updNeeded) |-> $past(addrWr));

  a_r6_full_cleared_by_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(bufRd));

  a_r7_no_ack_on_overflow: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfl) |-> !sdaOe);

  a_r8_no_ack_while_held: assert property (@(posedge clk) disable iff (!rstN)
    !(sclOe && sdaOe));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqClr));

  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclF);
endmodule

bind tbi_target tbi_target_chk uChk (
  .clk(clk), .rstN(rstN), .sclF(lineF[0]), .sclOe(sclOe), .sdaOe(sdaOe),
  .updNeeded(updNeeded), .addrWr(addrWr), .bufFull(bufFull), .bufRd(bufRd),
  .ovfl(ovfl), .irq(irq), .irqClr(irqClr)
);

// File: tb/sim_tbi_target.sv
module sim_tbi_target;
  localparam int FILT_LEN = 3;
  localparam int Q        = 12;
  localparam int LAT_FALL = 3 + FILT_LEN;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, sclGlitch = 1'b0;
  logic stretchEn = 1'b0, addrWr = 1'b0, bufRd = 1'b0, ovfClr = 1'b0, relWr = 1'b0, irqClr = 1'b0;
  logic [7:0] addrWdata = '0;
  logic sclOe, sdaOe, bufFull, ovfl, updNeeded, irq;
  logic [7:0] rxData;
  logic sclLine, sdaLine;

  assign sclLine = (sclDrv | sclGlitch) & ~sclOe;
  assign sdaLine = sdaDrv & ~sdaOe;

  tbi_target #(.FILT_LEN(FILT_LEN)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .stretchEn(stretchEn),
    .addrWr(addrWr), .addrWdata(addrWdata), .bufRd(bufRd),
    .rxData(rxData), .bufFull(bufFull), .ovfl(ovfl), .ovfClr(ovfClr),
    .updNeeded(updNeeded), .relWr(relWr), .irq(irq), .irqClr(irqClr)
  );

  int checks = 0, fails = 0;
  logic mFull = 1'b0, mOvf = 1'b0;
  logic [7:0] mData = '0;

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic wrAddr(input logic [7:0] v);
    addrWr = 1'b1; addrWdata = v; waitc(1); addrWr = 1'b0; waitc(1);
  endtask
  task automatic readBuf();
    bufRd = 1'b1; waitc(1); bufRd = 1'b0; waitc(1); mFull = 1'b0;
    chkEq("R6 read clears bufFull", bufFull, 0);
  endtask
  task automatic clrIrq();
    irqClr = 1'b1; waitc(1); irqClr = 1'b0; waitc(1);
    chkEq("R9 irqClr clears irq", irq, 0);
  endtask
  task automatic clrOvf();
    ovfClr = 1'b1; waitc(1); ovfClr = 1'b0; waitc(1); mOvf = 1'b0;
    chkEq("R7 ovfClr clears ovfl", ovfl, 0);
  endtask
  task automatic relPulse();
    relWr = 1'b1; waitc(1); relWr = 1'b0; waitc(1);
    chkEq("R8 relWr releases SCL", sclOe, 0);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitc(Q); sclDrv = 1'b1; waitSclHigh(); waitc(Q);
    sdaDrv = 1'b0; waitc(Q); sclDrv = 1'b0; waitc(Q);
  endtask
  task automatic stopCond();
    sdaDrv = 1'b0; waitc(Q); sclDrv = 1'b1; waitSclHigh(); waitc(Q);
    sdaDrv = 1'b1; waitc(Q);
  endtask

  // wrAt >= 0 places a compare-register write wrAt cycles after the ninth SCL fall
  task automatic sendByte(input logic [7:0] b, input int wrAt, input logic [7:0] wrVal,
                          input int glitchBit, output bit ack);
    bit early;
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i];
      if (i == glitchBit) begin
        waitc(3); sclGlitch = 1'b1; waitc(FILT_LEN - 1); sclGlitch = 1'b0;
        waitc(Q - 3 - (FILT_LEN - 1));
      end else begin
        waitc(Q);
      end
      sclDrv = 1'b1; waitSclHigh(); waitc(Q); sclDrv = 1'b0; waitc(Q);
    end
    sdaDrv = 1'b1; waitc(Q);
    sclDrv = 1'b1; waitSclHigh(); waitc(1);
    early = !sdaLine;
    waitc(Q - 1);
    ack = !sdaLine;
    chkEq("R12 ACK steady through ninth high phase", early, ack);
    sclDrv = 1'b0;
    if (wrAt >= 0) begin
      waitc(wrAt); addrWr = 1'b1; addrWdata = wrVal; waitc(1); addrWr = 1'b0;
      waitc(Q - wrAt - 1);
    end else begin
      waitc(Q);
    end
  endtask

  function automatic logic [7:0] hiPattern(input logic [9:0] a);
    return {5'b11110, a[9:8], 1'b0};
  endfunction

  task automatic doAddress(input logic [9:0] a, input bit badHi, input bit badLo, output bit ok);
    logic [7:0] hi, lo, b;
    bit ack;
    hi = hiPattern(a); lo = a[7:0]; ok = 1'b0;
    wrAddr(hi);
    startCond();
    b = badHi ? (hi ^ (8'h02 << ($urandom % 7))) : hi;
    sendByte(b, -1, 8'h00, -1, ack);
    chkEq("R2 first address byte ack", ack, int'(!badHi));
    if (badHi) begin
      chkEq("R2 no update flag on mismatch", updNeeded, 0);
      chkEq("R2 no hold on mismatch", sclOe, 0);
      chkEq("R2 no irq on mismatch", irq, 0);
      return;
    end
    chkEq("R3 update flag after high byte", updNeeded, 1);
    chkEq("R3 SCL held after high byte", sclOe, 1);
    chkEq("R9 irq after high byte", irq, 1);
    clrIrq();
    wrAddr(lo);
    chkEq("R3 write clears update flag", updNeeded, 0);
    chkEq("R3 write releases SCL", sclOe, 0);
    b = badLo ? (lo ^ (8'h01 << ($urandom % 8))) : lo;
    sendByte(b, -1, 8'h00, -1, ack);
    chkEq("R5 second address byte ack", ack, int'(!badLo));
    if (badLo) begin
      chkEq("R5 no update flag on mismatch", updNeeded, 0);
      chkEq("R5 no hold on mismatch", sclOe, 0);
      return;
    end
    chkEq("R3 update flag after low byte", updNeeded, 1);
    chkEq("R3 SCL held after low byte", sclOe, 1);
    chkEq("R9 irq after low byte", irq, 1);
    clrIrq();
    wrAddr(hi);
    chkEq("R3 second write clears update flag", updNeeded, 0);
    chkEq("R3 second write releases SCL", sclOe, 0);
    ok = 1'b1;
  endtask

  task automatic doData(input logic [7:0] d, input bit stretch, input bit doRead, input int glitchBit);
    bit ack, expAck;
    stretchEn = stretch;
    if (doRead) readBuf();
    expAck = !mFull;
    sendByte(d, -1, 8'h00, glitchBit, ack);
    if (expAck) begin mFull = 1'b1; mData = d; end
    else mOvf = 1'b1;
    chkEq(glitchBit >= 0 ? "R11 data ack despite SCL glitch" : "R6/R7 data ack", ack, int'(expAck));
    chkEq(glitchBit >= 0 ? "R11 data intact despite SCL glitch" : "R6 rxData", rxData, mData);
    chkEq("R6 bufFull", bufFull, mFull);
    chkEq("R7 ovfl", ovfl, mOvf);
    chkEq("R9 irq after data byte", irq, 1);
    chkEq("R8 data hold", sclOe, int'(expAck && stretch));
    if (expAck && stretch) relPulse();
    clrIrq();
  endtask

  task automatic doIgnored(input logic [7:0] d, input string req);
    bit ack;
    sendByte(d, -1, 8'h00, -1, ack);
    chkEq({req, " ignored byte NACK"}, ack, 0);
    chkEq({req, " ignored byte leaves bufFull"}, bufFull, mFull);
    chkEq({req, " ignored byte leaves irq"}, irq, 0);
    chkEq({req, " ignored byte no hold"}, sclOe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok, ack, expUa;
    logic [9:0] a;
    void'($urandom(32'd20240611));
    waitc(4);
    chkEq("R1 sclOe reset", sclOe, 0);
    chkEq("R1 sdaOe reset", sdaOe, 0);
    chkEq("R1 bufFull reset", bufFull, 0);
    chkEq("R1 ovfl reset", ovfl, 0);
    chkEq("R1 updNeeded reset", updNeeded, 0);
    chkEq("R1 irq reset", irq, 0);
    rstN = 1'b1;
    waitc(4);

    // basic transfer, stretch, overflow, recovery
    doAddress(10'h2A5, 1'b0, 1'b0, ok);
    doData(8'hC3, 1'b1, 1'b0, -1);
    doData(8'h5A, 1'b1, 1'b0, -1);
    readBuf();
    clrOvf();
    doData(8'h3C, 1'b0, 1'b0, -1);
    stopCond();

    // R10: bytes after STOP without START
    readBuf();
    doIgnored(8'hF0, "R10");

    // R11 glitch, then R10 repeated START mid-transfer
    doAddress(10'h1FF, 1'b0, 1'b0, ok);
    doData(8'hA7, 1'b0, 1'b0, 5);
    doAddress(10'h0E1, 1'b0, 1'b0, ok);
    chkEq("R10 repeated START re-addresses", ok, 1);
    doData(8'h19, 1'b0, 1'b1, -1);
    stopCond();

    // R2 / R5 mismatches ignore the rest of the transfer
    doAddress(10'h333, 1'b1, 1'b0, ok);
    doIgnored(8'h77, "R2");
    stopCond();
    doAddress(10'h333, 1'b0, 1'b1, ok);
    doIgnored(8'h88, "R5");
    stopCond();

    // R4: host write swept across the ninth-clock falling edge
    for (int k = 0; k <= 8; k++) begin
      a = 10'(10'h155 + k);
      wrAddr(hiPattern(a));
      startCond();
      sendByte(hiPattern(a), k, a[7:0], -1, ack);
      expUa = (k + 1 <= LAT_FALL);
      chkEq("R4 first byte ack", ack, 1);
      chkEq("R4 update flag vs write offset", updNeeded, int'(expUa));
      chkEq("R4 SCL hold vs write offset", sclOe, int'(expUa));
      if (expUa) begin
        wrAddr(a[7:0]);
        chkEq("R4 later write clears update flag", updNeeded, 0);
      end
      clrIrq();
      sendByte(a[7:0], -1, 8'h00, -1, ack);
      chkEq("R4 low byte matched written value", ack, 1);
      wrAddr(hiPattern(a));
      clrIrq();
      stopCond();
    end

    // constrained random transfers
    for (int t = 0; t < 16; t++) begin
      bit badHi, badLo, stretch;
      int nd;
      a = 10'($urandom);
      badHi = ($urandom % 8) == 0;
      badLo = !badHi && (($urandom % 8) == 0);
      stretch = $urandom % 2;
      doAddress(a, badHi, badLo, ok);
      nd = 1 + $urandom % 3;
      for (int j = 0; j < nd; j++) begin
        if (ok) doData(8'($urandom), stretch, ($urandom % 4) != 0, -1);
        else doIgnored(8'($urandom), "R2/R5");
      end
      if (mOvf && ($urandom % 2)) clrOvf();
      stopCond();
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule